// File: doc/BRIEF.md
# BCD Calendar Clock with Memory-Mapped Snapshot Registers

This block is a real-time calendar clock that sits in the top eight byte locations of a byte-wide address space. Live counters hold seconds, minutes, 24-hour hours, weekday, date, month, year and a century flag, all in BCD. They advance once for each one-cycle pulse on the seconds tick input. Software does not read or write the live counters directly. It uses a bank of snapshot (holding) registers, which copy the live counters on every clock cycle unless a halt bit in the control byte freezes them.

To read the time coherently, software sets the read-halt bit, reads the bytes and then clears the bit. To set the time, software sets the write-halt bit, writes the new values into the snapshot bytes and then clears the bit. Clearing it loads every snapshot field into the live counters in a single cycle. A stop bit freezes time-keeping. A frequency-test bit replaces bit 0 of the seconds byte with a square wave that toggles on each pulse of a test tick input.

Top module: `bcd_cal_clock`

## Requirements
- R1: The block answers when `sel` is high and `addr[ADDR_W-1:3]` are all ones. The low three address bits select the byte: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A read issued at a clock edge returns its byte on `rdata` after that edge. `rdata` then holds until the next read. A read outside the window returns 00h, and a write outside the window changes nothing.
- R2: On each seconds tick while running, seconds count 00–59 in BCD, then wrap to 00 and carry into minutes. Minutes count 00–59 in the same way, then carry into hours. Hours count 00–23, then carry into the date.
- R3: The date wraps to 01 after day 31 for months 01, 03, 05, 07, 08, 10 and 12, and after day 30 for months 04, 06, 09 and 11. February wraps after day 29 when the BCD year is a multiple of 4 and after day 28 otherwise. The month counts 01–12, and the year counts 00–99.
- R4: While control bit 6 (read halt) is 1, the snapshot bytes keep their values and the live counters keep running. Once the bit is cleared, reads show the advanced time.
- R5: While control bit 7 (write halt) is 1, writes to bytes 1–7 update the snapshot. Writing control bit 7 from 1 to 0 loads all seven time bytes into the live counters at once. While bit 7 is 0, writes to the time fields are ignored.
- R6: Seconds byte bit 7 is the stop bit. It resets to 1 and can be written at any time. While it is 1, ticks do not advance the time. After reset the bytes read control 00h, seconds 80h, minutes, hours and year 00h, and day, date and month 01h.
- R7: Day byte bit 5 is century-enable, which can be written at any time. Day byte bit 4 is the century flag. When the year wraps from 99 to 00, the century flag inverts if century-enable is 1 and holds its value if century-enable is 0.
- R8: Day byte bit 6 is frequency-test, which can be written at any time. While it is 1 and stop is 0, bit 0 of a seconds read returns a flag that inverts on every `ft_tick` pulse. The flag resets to 0.
- R9: Bits with no function read as 0: control bits 5–0, minutes bit 7, hours bits 7–6, day bits 7 and 3, date bits 7–6 and month bits 7–5. Any value written to them is dropped. A field that holds a value at or above its last legal value wraps to its first value on the next step, with a carry.
- R10: Day bits 2–0 hold the weekday. It steps once each time the hours carry into the date, and wraps from 7 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| sec_tick | input | 1 | One-cycle pulse per second |
| ft_tick | input | 1 | Pulse that inverts the frequency-test flag |
| rdata | output | 8 | Registered read data |

## Verification
A live counter changes at the clock edge where `sec_tick` is sampled high. The snapshot picks up that change one edge later, and a read returns it at the edge after the read is issued. The bench therefore drops the tick before any read and starts each read on the following falling edge, so a read samples `rdata` no earlier than three edges after the tick. A write, including the release of write halt, takes effect at the edge where it is sampled, and the snapshot follows one edge later. Reads are always issued after that point. Every result is sampled on a falling edge, half a cycle clear of the edge that produced it.

// File: rtl/cal_clock_pkg.sv
// Package: shared time record, reset value and BCD helper functions
// for the calendar clock. Assumes all fields hold packed BCD digits.
package cal_clock_pkg;

    typedef struct packed {
        logic       cent;
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] minute;
        logic [6:0] second;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{cent: 1'b0, year: 8'h00, month: 5'h01,
                                        date: 6'h01, wday: 3'd1, hour: 6'h00,
                                        minute: 7'h00, second: 7'h00};

    // Step a BCD value; wrap to first when at or past last.
    function automatic logic [7:0] bcd_next(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v >= last)
            return first;
        if (v[3:0] >= 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    // Leap test on a BCD year: multiple of four.
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
        return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    endfunction

    // Last date of a BCD month.
    function automatic logic [7:0] month_last(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_counters.sv
// Live time counters. Advances the full BCD calendar by one second
// when 'advance' is high; a 'load' takes priority and copies load_val.
// Assumes advance is a single-cycle pulse already gated by the stop bit.
module cal_counters
    import cal_clock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance,
    input  logic      load,
    input  cal_time_t load_val,
    input  logic      century_en,
    output cal_time_t now
);

    logic       c_sec, c_min, c_hour, c_date, c_mon, c_year;
    logic [7:0] last_day;
    logic [7:0] n_sec, n_min, n_hour, n_date, n_mon, n_year;
    logic [2:0] n_wday;
    cal_time_t  stepped;

    // Carry chain: each field carries when it reaches its last value.
    always_comb begin
        last_day = month_last(now.month, bcd_leap(now.year));
        c_sec    = {1'b0, now.second} >= 8'h59;
        c_min    = c_sec  && ({1'b0, now.minute} >= 8'h59);
        c_hour   = c_min  && ({2'b0, now.hour} >= 8'h23);
        c_date   = c_hour && ({2'b0, now.date} >= last_day);
        c_mon    = c_date && ({3'b0, now.month} >= 8'h12);
        c_year   = c_mon  && (now.year >= 8'h99);
    end

    // Next values for every field after one second.
    always_comb begin
        n_sec   = bcd_next({1'b0, now.second}, 8'h59, 8'h00);
        n_min   = bcd_next({1'b0, now.minute}, 8'h59, 8'h00);
        n_hour  = bcd_next({2'b0, now.hour},   8'h23, 8'h00);
        n_date  = bcd_next({2'b0, now.date},   last_day, 8'h01);
        n_mon   = bcd_next({3'b0, now.month},  8'h12, 8'h01);
        n_year  = bcd_next(now.year,           8'h99, 8'h00);
        n_wday  = (now.wday >= 3'd7) ? 3'd1 : now.wday + 3'd1;
        stepped = now;
        stepped.second = n_sec[6:0];
        if (c_sec)  stepped.minute = n_min[6:0];
        if (c_min)  stepped.hour   = n_hour[5:0];
        if (c_hour) begin
            stepped.date = n_date[5:0];
            stepped.wday = n_wday;
        end
        if (c_date) stepped.month = n_mon[4:0];
        if (c_mon)  stepped.year  = n_year;
        if (c_year && century_en) stepped.cent = ~now.cent;
    end

    // Counter register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= CAL_RESET;
        else if (load)
            now <= load_val;
        else if (advance)
            now <= stepped;
    end

    a_r5_load_all_fields: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now == $past(load_val)));

    a_r6_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(now));

    a_r2_second_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && now.second == 7'h59) |=> (now.second == 7'h00));

    a_r7_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && now.year == 8'h99 && c_mon && century_en)
        |=> (now.cent != $past(now.cent)));

    a_r10_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && c_hour && now.wday == 3'd7) |=> (now.wday == 3'd1));

endmodule

// File: rtl/cal_regs.sv
// Bus-facing register bank: control byte, snapshot of the time, the
// always-writable mode bits (stop, frequency test, century enable),
// frequency-test flag and the registered read port.
// Assumes a read or write is one cycle long with sel high.
module cal_regs
    import cal_clock_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ft_tick,
    input  cal_time_t         live,
    output cal_time_t         snap,
    output logic              load,
    output logic              stopped,
    output logic              century_en,
    output logic [7:0]        rdata
);

    localparam int HI_W = ADDR_W - 3;

    logic       hit, wr_hit, rd_any;
    logic [2:0] off;
    logic       wr_halt, rd_halt, ft_en, ft_flag;
    logic [7:0] rd_mux;

    // Address decode for the top eight bytes.
    always_comb begin
        hit    = sel && (addr[ADDR_W-1:3] == {HI_W{1'b1}});
        off    = addr[2:0];
        wr_hit = hit && we;
        rd_any = sel && !we;
        load   = wr_hit && (off == 3'd0) && wr_halt && !wdata[7];
    end

    // Control byte halt bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_halt <= 1'b0;
            rd_halt <= 1'b0;
        end else if (wr_hit && off == 3'd0) begin
            wr_halt <= wdata[7];
            rd_halt <= wdata[6];
        end
    end

    // Mode bits that take effect without the write halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped    <= 1'b1;
            ft_en      <= 1'b0;
            century_en <= 1'b0;
        end else if (wr_hit && off == 3'd1) begin
            stopped <= wdata[7];
        end else if (wr_hit && off == 3'd4) begin
            ft_en      <= wdata[6];
            century_en <= wdata[5];
        end
    end

    // Frequency-test flag inverts on each test tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ft_flag <= 1'b0;
        else if (ft_tick)
            ft_flag <= ~ft_flag;
    end

    // Snapshot: follow live time unless halted; accept writes under write halt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= CAL_RESET;
        else if (!(wr_halt || rd_halt))
            snap <= live;
        else if (wr_hit && wr_halt) begin
            case (off)
                3'd1: snap.second <= wdata[6:0];
                3'd2: snap.minute <= wdata[6:0];
                3'd3: snap.hour   <= wdata[5:0];
                3'd4: begin
                    snap.cent <= wdata[4];
                    snap.wday <= wdata[2:0];
                end
                3'd5: snap.date   <= wdata[5:0];
                3'd6: snap.month  <= wdata[4:0];
                3'd7: snap.year   <= wdata;
                default: ;
            endcase
        end
    end

    // Read multiplexer over the eight bytes.
    always_comb begin
        case (off)
            3'd0: rd_mux = {wr_halt, rd_halt, 6'b0};
            3'd1: rd_mux = {stopped, snap.second[6:1],
                            (ft_en && !stopped) ? ft_flag : snap.second[0]};
            3'd2: rd_mux = {1'b0, snap.minute};
            3'd3: rd_mux = {2'b0, snap.hour};
            3'd4: rd_mux = {1'b0, ft_en, century_en, snap.cent, 1'b0, snap.wday};
            3'd5: rd_mux = {2'b0, snap.date};
            3'd6: rd_mux = {3'b0, snap.month};
            default: rd_mux = snap.year;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_any)
            rdata <= hit ? rd_mux : 8'h00;
    end

    a_r4_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_halt && !wr_halt) |=> $stable(snap));

    a_r5_no_write_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_halt && !rd_halt) |=> (snap == $past(live)));

    a_r9_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && hit && off == 3'd0) |=> (rdata[5:0] == 6'b0));

    a_r1_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !hit) |=> (rdata == 8'h00));

endmodule

// File: rtl/bcd_cal_clock.sv
// Top: memory-mapped BCD calendar clock. Joins the bus register bank
// to the live counters; ticks are gated by the stop bit here.
// Assumes sec_tick and ft_tick are single-cycle pulses in clk domain.
module bcd_cal_clock
    import cal_clock_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              sec_tick,
    input  logic              ft_tick,
    output logic [7:0]        rdata
);

    cal_time_t live, snap;
    logic      load, stopped, century_en, advance;

    // Time advances only on a tick while running.
    assign advance = sec_tick && !stopped;

    cal_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .we         (we),
        .addr       (addr),
        .wdata      (wdata),
        .ft_tick    (ft_tick),
        .live       (live),
        .snap       (snap),
        .load       (load),
        .stopped    (stopped),
        .century_en (century_en),
        .rdata      (rdata)
    );

    cal_counters u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .load       (load),
        .load_val   (snap),
        .century_en (century_en),
        .now        (live)
    );

    a_r6_stop_blocks_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !load) |=> $stable(live));

endmodule

// File: tb/bcd_cal_clock_test.sv
module bcd_cal_clock_test;

    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'h00;
    logic              sec_tick = 1'b0;
    logic              ft_tick = 1'b0;
    logic [7:0]        rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bcd_cal_clock #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr),
        .wdata(wdata), .sec_tick(sec_tick), .ft_tick(ft_tick), .rdata(rdata)
    );

    function automatic logic [ADDR_W-1:0] win(input logic [2:0] off);
        return {{(ADDR_W-3){1'b1}}, off};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        d = rdata;
    endtask

    task automatic expect_byte(input string tag, input logic [2:0] off, input logic [7:0] exp);
        logic [7:0] d;
        bus_rd(win(off), d);
        check(tag, d, exp);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic ftick();
        @(negedge clk); ft_tick = 1'b1;
        @(negedge clk); ft_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dy, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] y);
        bus_wr(win(0), 8'h80);
        bus_wr(win(1), s);
        bus_wr(win(2), m);
        bus_wr(win(3), h);
        bus_wr(win(4), dy);
        bus_wr(win(5), dt);
        bus_wr(win(6), mo);
        bus_wr(win(7), y);
        bus_wr(win(0), 8'h00);
    endtask

    task automatic t_reset();
        expect_byte("R6 reset ctl",   0, 8'h00);
        expect_byte("R6 reset sec",   1, 8'h80);
        expect_byte("R6 reset min",   2, 8'h00);
        expect_byte("R6 reset day",   4, 8'h01);
        expect_byte("R6 reset date",  5, 8'h01);
        expect_byte("R6 reset month", 6, 8'h01);
        expect_byte("R6 reset year",  7, 8'h00);
        tick();
        expect_byte("R6 stopped after reset", 1, 8'h80);
    endtask

    task automatic t_year_end();
        set_time(8'h58, 8'h59, 8'h23, 8'h27, 8'h31, 8'h12, 8'h99);
        expect_byte("R5 loaded seconds", 1, 8'h58);
        expect_byte("R5 loaded day", 4, 8'h27);
        tick();
        expect_byte("R2 second step", 1, 8'h59);
        tick();
        expect_byte("R2 second wrap", 1, 8'h00);
        expect_byte("R2 minute wrap", 2, 8'h00);
        expect_byte("R2 hour wrap",   3, 8'h00);
        expect_byte("R7 R10 day byte century and weekday", 4, 8'h31);
        expect_byte("R3 date wrap",   5, 8'h01);
        expect_byte("R3 month wrap",  6, 8'h01);
        expect_byte("R3 year wrap",   7, 8'h00);
    endtask

    task automatic t_months();
        set_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h28, 8'h02, 8'h24);
        tick();
        expect_byte("R3 leap feb 29 date", 5, 8'h29);
        expect_byte("R3 leap feb month",   6, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h29, 8'h02, 8'h24);
        tick();
        expect_byte("R3 leap feb end date", 5, 8'h01);
        expect_byte("R3 leap feb end month", 6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h28, 8'h02, 8'h23);
        tick();
        expect_byte("R3 plain feb end date",  5, 8'h01);
        expect_byte("R3 plain feb end month", 6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h30, 8'h04, 8'h23);
        tick();
        expect_byte("R3 april end date",  5, 8'h01);
        expect_byte("R3 april end month", 6, 8'h05);
        expect_byte("R3 april end year",  7, 8'h23);
    endtask

    task automatic t_read_halt();
        bus_wr(win(0), 8'h40);
        expect_byte("R4 halt ctl", 0, 8'h40);
        tick(); tick(); tick();
        expect_byte("R4 frozen sec", 1, 8'h00);
        bus_wr(win(0), 8'h00);
        expect_byte("R4 resumed sec", 1, 8'h03);
    endtask

    task automatic t_ignored();
        bus_wr(win(2), 8'h33);
        expect_byte("R5 write without halt ignored", 2, 8'h00);
        bus_wr({ADDR_W{1'b0}} | 15'h0001, 8'h55);
        expect_byte("R1 outside write no effect", 1, 8'h03);
        begin
            logic [7:0] d;
            bus_rd({ADDR_W{1'b0}} | 15'h0001, d);
            check("R1 outside read zero", d, 8'h00);
            repeat (3) @(negedge clk);
            check("R1 rdata holds", rdata, 8'h00);
        end
        bus_wr(win(0), 8'hFF);
        expect_byte("R9 ctl unused bits", 0, 8'hC0);
        bus_wr(win(0), 8'h00);
        expect_byte("R5 release kept time", 1, 8'h03);
    endtask

    task automatic t_stop();
        bus_wr(win(1), 8'h80);
        expect_byte("R6 stop set", 1, 8'h83);
        tick();
        expect_byte("R6 no advance when stopped", 1, 8'h83);
        bus_wr(win(1), 8'h00);
        tick();
        expect_byte("R6 restarted", 1, 8'h04);
    endtask

    task automatic t_ftest();
        bus_wr(win(4), 8'h40);
        expect_byte("R8 ft flag low", 1, 8'h04);
        ftick();
        expect_byte("R8 ft flag high", 1, 8'h05);
        ftick();
        expect_byte("R8 ft flag low again", 1, 8'h04);
        bus_wr(win(1), 8'h80);
        ftick();
        expect_byte("R8 no ft when stopped", 1, 8'h84);
        bus_wr(win(4), 8'h00);
        bus_wr(win(1), 8'h00);
        expect_byte("R8 ft off", 1, 8'h04);
    endtask

    task automatic t_invalid();
        set_time(8'h59, 8'hFF, 8'h05, 8'h11, 8'h10, 8'h06, 8'h30);
        expect_byte("R9 minute mask", 2, 8'h7F);
        tick();
        expect_byte("R9 bad minute wraps", 2, 8'h00);
        expect_byte("R9 bad minute carries", 3, 8'h06);
    endtask

    task automatic t_century_off();
        set_time(8'h59, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99);
        tick();
        expect_byte("R7 century held, R10 weekday wraps", 4, 8'h11);
        expect_byte("R7 year wrap", 7, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h13, 8'h31, 8'h12, 8'h99);
        tick();
        expect_byte("R10 weekday step", 4, 8'h14);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_year_end();
        t_months();
        t_read_halt();
        t_ignored();
        t_stop();
        t_ftest();
        t_invalid();
        t_century_off();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule